// File: doc/BRIEF.md
# Shifted Parallel Comparator Cluster Array

This block compares a short reference string against a window of text in a single combinational step. The window is read by several comparator clusters. Each cluster is as wide as the reference. Cluster k begins its comparison k characters into the window, so one evaluation tests every overlapping alignment of the reference across a span of text that is wider than any single cluster. The block holds no state. The surrounding engine keeps the text buffer, decodes the instructions and supplies a fresh window and reference each cycle.

Two comparison modes exist. In the conjunctive mode (AND), a cluster matches when every active reference character equals the text character it is aligned with. In the alternative mode (OR), a cluster matches when any active reference character equals the single text character at the cluster's starting position. The reference length input selects how many of the leading reference characters are active. A length of zero means an empty reference, which every cluster accepts. The block outputs a per-cluster hit vector, the index of the lowest-numbered hitting cluster (the earliest match offset) and a flag that is set when any cluster hits.

Top module: `shift_cmp_array`

## Requirements
- R1: The block is purely combinational. Its outputs follow the present inputs with no clock and no stored state.
- R2: Window character i sits at bits [8i+7:8i] of `text_win`, and reference character j sits at bits [8j+7:8j] of `ref_chars`. Cluster k aligns reference character j with window character k+j.
- R3: With `op_or` = 0 (AND mode) and an effective length L > 0, cluster k hits exactly when reference character j equals window character k+j for every j < L.
- R4: With `op_or` = 1 (OR mode) and L > 0, cluster k hits exactly when at least one reference character j < L equals window character k.
- R5: A `ref_len` value greater than the cluster width is treated as the full cluster width.
- R6: With `ref_len` = 0, every cluster hits in both modes.
- R7: `first_idx` is the lowest index k with `hit_vec[k]` set. It is 0 when no cluster hits.
- R8: `any_hit` is 1 exactly when at least one bit of `hit_vec` is set.
- R9: Reference characters at positions j >= L do not affect any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| text_win | input | (N_CLUSTER+CLUSTER_W-1)*CHAR_W | Text window; character 0 is in the low bits |
| ref_chars | input | CLUSTER_W*CHAR_W | Reference characters; character 0 is in the low bits |
| ref_len | input | clog2(CLUSTER_W+1) | Number of active leading reference characters |
| op_or | input | 1 | Selects the comparison mode: 0 for AND, 1 for OR |
| hit_vec | output | N_CLUSTER | Per-cluster match result |
| first_idx | output | clog2(N_CLUSTER) | Index of the lowest hitting cluster |
| any_hit | output | 1 | Set when any cluster hits |

## Verification
The bench sweeps every window and every reference over a two-letter alphabet, every length code and both modes. This covers the corner cases that hurt most.

- A cluster attached one character off in the window gives hits at the wrong offsets whenever the text is asymmetric.
- An OR mode that compares each reference character with its own aligned position, rather than with the cluster's first character, disagrees on windows such as "ba..." matched against the reference "ab".
- A length mask that is off by one, or that wraps instead of clamping for codes above the width, either lets an inactive character veto a match or drops an active character.
- An empty reference that reports no hit in OR mode is also caught.
- A priority encoder that favours the highest index shows up on any window with two hits.

// File: rtl/shift_cmp_pkg.sv
package shift_cmp_pkg;

  typedef enum logic {
    CMP_ALL = 1'b0,
    CMP_ANY = 1'b1
  } cmp_op_e;

endpackage

// File: rtl/cmp_cluster.sv
module cmp_cluster
  import shift_cmp_pkg::*;
#(
  parameter int CLUSTER_W = 4,
  parameter int CHAR_W    = 8
) (
  input  logic [CLUSTER_W*CHAR_W-1:0] seg,
  input  logic [CLUSTER_W*CHAR_W-1:0] refc,
  input  logic [CLUSTER_W-1:0]        act_mask,
  input  cmp_op_e                     op,
  output logic                        hit
);

  logic [CLUSTER_W-1:0] eq_aligned;
  logic [CLUSTER_W-1:0] eq_first;

  for (genvar j = 0; j < CLUSTER_W; j++) begin : g_pos
    assign eq_aligned[j] = (refc[j*CHAR_W +: CHAR_W] == seg[j*CHAR_W +: CHAR_W]);
    assign eq_first[j]   = (refc[j*CHAR_W +: CHAR_W] == seg[CHAR_W-1:0]);
  end

  logic all_ok;
  logic any_ok;
  assign all_ok = &(eq_aligned | ~act_mask);
  assign any_ok = (act_mask == '0) || (|(eq_first & act_mask));

  always_comb begin
    if (op == CMP_ALL) hit = all_ok;
    else               hit = any_ok;
  end

  // R3: in AND mode a hit with an active first position needs that character equal
  always_comb begin
    if (hit && op == CMP_ALL && act_mask[0])
      a_r3_and_first_equal: assert (refc[CHAR_W-1:0] == seg[CHAR_W-1:0])
        else $error("a_r3_and_first_equal");
  end

endmodule

// File: rtl/first_hit_enc.sv
module first_hit_enc #(
  parameter int N_IN  = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_IN-1:0]  req,
  output logic [IDX_W-1:0] idx,
  output logic             found
);

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/shift_cmp_array.sv
module shift_cmp_array
  import shift_cmp_pkg::*;
#(
  parameter int N_CLUSTER = 4,
  parameter int CLUSTER_W = 4,
  parameter int CHAR_W    = 8,
  localparam int WIN_LEN  = N_CLUSTER + CLUSTER_W - 1,
  localparam int LEN_W    = $clog2(CLUSTER_W + 1),
  localparam int IDX_W    = (N_CLUSTER > 1) ? $clog2(N_CLUSTER) : 1
) (
  input  logic [WIN_LEN*CHAR_W-1:0]   text_win,
  input  logic [CLUSTER_W*CHAR_W-1:0] ref_chars,
  input  logic [LEN_W-1:0]            ref_len,
  input  logic                        op_or,
  output logic [N_CLUSTER-1:0]        hit_vec,
  output logic [IDX_W-1:0]            first_idx,
  output logic                        any_hit
);

  // Clamp the length to the cluster width, then expand it to a mask
  logic [LEN_W-1:0]     eff_len;
  logic [CLUSTER_W-1:0] act_mask;
  cmp_op_e              op_sel;

  assign eff_len = (ref_len > LEN_W'(CLUSTER_W)) ? LEN_W'(CLUSTER_W) : ref_len;
  assign op_sel  = cmp_op_e'(op_or);

  for (genvar j = 0; j < CLUSTER_W; j++) begin : g_mask
    assign act_mask[j] = (LEN_W'(j) < eff_len);
  end

  // Cluster k looks at window characters k .. k+CLUSTER_W-1
  for (genvar k = 0; k < N_CLUSTER; k++) begin : g_cl
    cmp_cluster #(
      .CLUSTER_W (CLUSTER_W),
      .CHAR_W    (CHAR_W)
    ) u_cl (
      .seg      (text_win[k*CHAR_W +: CLUSTER_W*CHAR_W]),
      .refc     (ref_chars),
      .act_mask (act_mask),
      .op       (op_sel),
      .hit      (hit_vec[k])
    );
  end

  first_hit_enc #(
    .N_IN  (N_CLUSTER),
    .IDX_W (IDX_W)
  ) u_enc (
    .req   (hit_vec),
    .idx   (first_idx),
    .found (any_hit)
  );

  // R8: the flag agrees with the cluster vector
  always_comb begin
    a_r8_any_matches_vec: assert (any_hit == (hit_vec != '0))
      else $error("a_r8_any_matches_vec");
  end

  // R7: the reported cluster hits and no lower cluster hits
  always_comb begin
    if (any_hit) begin
      a_r7_idx_hits: assert (hit_vec[first_idx])
        else $error("a_r7_idx_hits");
      for (int i = 0; i < N_CLUSTER; i++) begin
        if (IDX_W'(i) < first_idx)
          a_r7_none_below: assert (!hit_vec[i])
            else $error("a_r7_none_below");
      end
    end else begin
      a_r7_idx_zero: assert (first_idx == '0)
        else $error("a_r7_idx_zero");
    end
  end

  // R6: an empty reference is accepted everywhere
  always_comb begin
    if (ref_len == '0)
      a_r6_empty_all_hit: assert (&hit_vec)
        else $error("a_r6_empty_all_hit");
  end

endmodule

// File: tb/sim_shift_cmp_array.sv
module sim_shift_cmp_array;

  localparam int N  = 4;
  localparam int W  = 4;
  localparam int C  = 8;
  localparam int WL = N + W - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [WL*C-1:0] text_win;
  logic [W*C-1:0]  ref_chars;
  logic [2:0]      ref_len;
  logic            op_or;
  logic [N-1:0]    hit_vec;
  logic [1:0]      first_idx;
  logic            any_hit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  shift_cmp_array u0 (
    .text_win  (text_win),
    .ref_chars (ref_chars),
    .ref_len   (ref_len),
    .op_or     (op_or),
    .hit_vec   (hit_vec),
    .first_idx (first_idx),
    .any_hit   (any_hit)
  );

  function automatic logic [7:0] tch(input logic [WL*C-1:0] t, input int i);
    return t[i*C +: C];
  endfunction

  function automatic logic [7:0] rch(input logic [W*C-1:0] r, input int j);
    return r[j*C +: C];
  endfunction

  // Reference model built from R2 to R6; positions at or past L are never read (R9)
  function automatic logic [N-1:0] model_hits(input logic [WL*C-1:0] t,
                                              input logic [W*C-1:0] r,
                                              input int len, input bit orm);
    logic [N-1:0] h;
    int L;
    L = (len > W) ? W : len;
    for (int k = 0; k < N; k++) begin
      bit ok;
      if (L == 0) ok = 1;
      else if (!orm) begin
        ok = 1;
        for (int j = 0; j < L; j++) if (rch(r, j) != tch(t, k + j)) ok = 0;
      end else begin
        ok = 0;
        for (int j = 0; j < L; j++) if (rch(r, j) == tch(t, k)) ok = 1;
      end
      h[k] = ok;
    end
    return h;
  endfunction

  function automatic logic [1:0] model_first(input logic [N-1:0] h);
    for (int k = 0; k < N; k++) if (h[k]) return 2'(k);
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input int len, input bit orm);
    logic [N-1:0] eh;
    string tag;
    eh = model_hits(text_win, ref_chars, len, orm);
    if (len == 0)      tag = "R6";
    else if (len > W)  tag = "R5";
    else if (!orm)     tag = "R3";
    else               tag = "R4";
    check({tag, "/R2 hit_vec"}, 32'(hit_vec), 32'(eh));
    check("R7 first_idx", 32'(first_idx), 32'(model_first(eh)));
    check("R8 any_hit", 32'(any_hit), 32'(|eh));
  endtask

  initial begin
    text_win  = '0;
    ref_chars = '0;
    ref_len   = '0;
    op_or     = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: empty reference, every cluster hits (R6)
    check("R6 idle hit_vec", 32'(hit_vec), 32'hF);
    check("R7 idle first_idx", 32'(first_idx), 32'h0);

    // R2: "ab" placed only at window offset 2
    text_win  = {"zzzzab", "y"};
    // character 0 is in the low bits, so build the window explicitly
    for (int i = 0; i < WL; i++) text_win[i*C +: C] = "z";
    text_win[2*C +: C] = "a";
    text_win[3*C +: C] = "b";
    ref_chars = '0;
    ref_chars[0 +: C] = "a";
    ref_chars[C +: C] = "b";
    ref_len = 3'd2;
    op_or   = 1'b0;
    #1;
    // R1: outputs follow the inputs with no clock edge in between
    check("R1/R2 offset2 hit_vec", 32'(hit_vec), 32'h4);
    check("R2 offset2 first_idx", 32'(first_idx), 32'h2);

    // R9: the characters past L must not matter
    for (int len = 0; len < W; len++) begin
      logic [N-1:0] h0;
      for (int i = 0; i < WL; i++) text_win[i*C +: C] = (i % 2) ? "b" : "a";
      for (int j = 0; j < W; j++) ref_chars[j*C +: C] = "a";
      ref_len = 3'(len);
      op_or   = 1'b0;
      #1 h0 = hit_vec;
      for (int j = len; j < W; j++) ref_chars[j*C +: C] = "q";
      #1 check("R9 unused ref chars", 32'(hit_vec), 32'(h0));
    end

    // Exhaustive sweep over a two-letter alphabet
    for (int tp = 0; tp < (1 << WL); tp++)
      for (int rp = 0; rp < (1 << W); rp++)
        for (int len = 0; len < 8; len++)
          for (int m = 0; m < 2; m++) begin
            @(posedge clk);
            for (int i = 0; i < WL; i++) text_win[i*C +: C] = 8'("a" + ((tp >> i) & 1));
            for (int j = 0; j < W; j++) ref_chars[j*C +: C] = 8'("a" + ((rp >> j) & 1));
            ref_len = 3'(len);
            op_or   = m[0];
            @(negedge clk);
            check_all(len, m[0]);
          end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule